// File: doc/BRIEF.md
# Line Loopback and All-Ones Transmit Selector

This block sits between the framer side and the line side of a T1/E1 line interface and decides where each clock and dual-rail data pair goes. In normal operation the framer's transmit clock and rails go out to the line. The clock and rails recovered from the line go through an external jitter attenuator before they reach the framer's receive outputs. The block adds three maintenance modes: local loopback, remote loopback and continuous all-ones (alarm indication) transmission.

Each mode has two request inputs, a dedicated pin and a control-register bit, and a mode is requested when either one is high. Requests are captured on the rising edge of the transmit clock, and fixed priority rules resolve them. Remote loopback beats both other modes. Local loopback and all-ones can be active together, because one acts on the receive side and the other on the line side.

The attenuator is outside the block. The block drives the attenuator's input and takes its output back through ports. In all-ones mode an internal generator produces AMI marks that alternate between the two rails on every transmit clock.

Top module: `line_loop_sel`

## Requirements
- R1: Each mode (local, remote, all-ones) is requested when its pin input or its register-bit input is high. The two sources of a mode are interchangeable.
- R2: Mode requests are sampled on the rising edge of `tx_clk`, so a change shows on the outputs only after the next rising edge. After reset the block is in normal mode.
- R3: `mode_state` reports the resolved mode as 0 for normal, 1 for local loopback, 2 for remote loopback and 3 for all-ones. When several modes are requested, remote is reported over local, and local over all-ones.
- R4: In local loopback without remote, the attenuator input takes `tx_clk`, `tx_pos` and `tx_neg`. The receive outputs therefore follow the transmit side, and `rx_clk`, `rx_pos` and `rx_neg` have no effect on them.
- R5: In local loopback with no all-ones request, the line outputs still carry `tx_clk`, `tx_pos` and `tx_neg`.
- R6: In all-ones mode without remote, the line clock is `tx_clk` and the transmit rails are ignored. The line rails carry exactly one mark per clock, alternating between `line_pos` and `line_neg`, and never both at once.
- R7: In remote loopback, the attenuator input takes the recovered `rx_*` signals. The attenuator output drives both the line outputs and the receive outputs, and any all-ones request is ignored.
- R8: In normal mode, the line outputs carry the `tx_*` signals, the attenuator input takes the `rx_*` signals, and the receive outputs take the attenuator output.
- R9: The first mark after reset, or after each entry into all-ones mode, is on `line_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | Transmit clock from the framer |
| tx_pos | input | 1 | Transmit positive rail |
| tx_neg | input | 1 | Transmit negative rail |
| rx_clk | input | 1 | Clock recovered from the line |
| rx_pos | input | 1 | Recovered positive rail |
| rx_neg | input | 1 | Recovered negative rail |
| pin_loc | input | 1 | Local loopback request pin |
| pin_rem | input | 1 | Remote loopback request pin |
| pin_ones | input | 1 | All-ones request pin |
| bit_loc | input | 1 | Local loopback register bit |
| bit_rem | input | 1 | Remote loopback register bit |
| bit_ones | input | 1 | All-ones register bit |
| ja_in_clk | output | 1 | Clock to the jitter attenuator |
| ja_in_pos | output | 1 | Positive rail to the attenuator |
| ja_in_neg | output | 1 | Negative rail to the attenuator |
| ja_out_clk | input | 1 | Clock from the jitter attenuator |
| ja_out_pos | input | 1 | Positive rail from the attenuator |
| ja_out_neg | input | 1 | Negative rail from the attenuator |
| line_clk | output | 1 | Clock to the line driver |
| line_pos | output | 1 | Positive rail to the line driver |
| line_neg | output | 1 | Negative rail to the line driver |
| sys_clk | output | 1 | Receive clock to the framer |
| sys_pos | output | 1 | Receive positive rail to the framer |
| sys_neg | output | 1 | Receive negative rail to the framer |
| mode_state | output | 2 | Resolved mode code (see R3) |

## Verification
The bench drives remote together with all-ones, and local together with all-ones. A design with the wrong priority would send alarm marks over a remote loopback, or would drop the local receive path whenever all-ones is set. The bench leaves all-ones mode and enters it again to check that polarity restarts on the positive rail. It also holds all-ones for long runs, where a stuck toggle would show as repeated marks on one rail. Before each rising edge it checks that a new request has not yet reached `mode_state`. A combinational path around the mode register would show a change one edge early.

// File: rtl/line_loop_pkg.sv
`timescale 1ns/1ps
package line_loop_pkg;

  localparam int NUM_CTRL = 3;
  localparam int CTRL_LOC = 0;
  localparam int CTRL_REM = 1;
  localparam int CTRL_ONES = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOCAL  = 2'd1,
    MODE_REMOTE = 2'd2,
    MODE_ONES   = 2'd3
  } loop_mode_e;

  typedef struct packed {
    logic rem;
    logic loc;
    logic ones;
  } loop_sel_s;

  typedef struct packed {
    logic clk;
    logic pos;
    logic neg;
  } rail_bundle_s;

  function automatic loop_sel_s resolve_sel(input logic [NUM_CTRL-1:0] req);
    loop_sel_s s;
    s.rem  = req[CTRL_REM];
    s.loc  = req[CTRL_LOC] & ~req[CTRL_REM];
    s.ones = req[CTRL_ONES] & ~req[CTRL_REM];
    return s;
  endfunction

  function automatic loop_mode_e encode_mode(input loop_sel_s s);
    if (s.rem)       return MODE_REMOTE;
    else if (s.loc)  return MODE_LOCAL;
    else if (s.ones) return MODE_ONES;
    else             return MODE_NORMAL;
  endfunction

  function automatic rail_bundle_s pick_bundle(input logic use_b,
                                               input rail_bundle_s a,
                                               input rail_bundle_s b);
    return use_b ? b : a;
  endfunction

endpackage

// File: rtl/line_loop_mode_ctl.sv
`timescale 1ns/1ps
module line_loop_mode_ctl
  import line_loop_pkg::*;
#(
  parameter int N_CTRL = NUM_CTRL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CTRL-1:0] req_pin,
  input  logic [N_CTRL-1:0] req_bit,
  output loop_sel_s         sel,
  output loop_mode_e        mode
);

  logic [N_CTRL-1:0] req_any;
  logic [N_CTRL-1:0] req_q;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_req
    assign req_any[i] = req_pin[i] | req_bit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= req_any[i];
    end

    AST_REQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_pin[i] || req_bit[i]) |=> req_q[i]); // R1
    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_pin[i] && !req_bit[i]) |=> !req_q[i]); // R2
  end

  assign sel  = resolve_sel(req_q);
  assign mode = encode_mode(sel);

  AST_REMOTE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[CTRL_REM] |-> (mode == MODE_REMOTE && !sel.ones)); // R3

endmodule

// File: rtl/line_loop_ones_gen.sv
`timescale 1ns/1ps
module line_loop_ones_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic mark_pos,
  output logic mark_neg
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= 1'b0;
    else if (active) phase_q <= ~phase_q;
    else             phase_q <= 1'b0;
  end

  assign mark_pos = active & ~phase_q;
  assign mark_neg = active & phase_q;

  AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (mark_pos ^ mark_neg)); // R6
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (mark_pos == $past(mark_neg))); // R6
  AST_START_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> mark_pos); // R9

endmodule

// File: rtl/line_loop_route.sv
`timescale 1ns/1ps
module line_loop_route
  import line_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  loop_sel_s    sel,
  input  rail_bundle_s tx_b,
  input  rail_bundle_s rx_b,
  input  rail_bundle_s ja_out_b,
  input  logic         ones_pos,
  input  logic         ones_neg,
  output rail_bundle_s ja_in_b,
  output rail_bundle_s line_b,
  output rail_bundle_s sys_b
);

  rail_bundle_s ones_b;
  rail_bundle_s tx_side_b;

  assign ones_b    = '{clk: tx_b.clk, pos: ones_pos, neg: ones_neg};
  assign tx_side_b = pick_bundle(sel.ones, tx_b, ones_b);
  assign ja_in_b   = pick_bundle(sel.loc, rx_b, tx_b);
  assign line_b    = pick_bundle(sel.rem, tx_side_b, ja_out_b);
  assign sys_b     = ja_out_b;

  AST_LOCAL_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    sel.loc |-> (ja_in_b.pos == tx_b.pos && ja_in_b.neg == tx_b.neg)); // R4
  AST_REMOTE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sel.rem |-> (line_b.pos == ja_out_b.pos && line_b.neg == ja_out_b.neg)); // R7
  AST_ONES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sel.ones |-> (line_b.pos != line_b.neg)); // R6

endmodule

// File: rtl/line_loop_sel.sv
`timescale 1ns/1ps
module line_loop_sel
  import line_loop_pkg::*;
(
  input  logic       rst_n,
  input  logic       tx_clk,
  input  logic       tx_pos,
  input  logic       tx_neg,
  input  logic       rx_clk,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic       pin_loc,
  input  logic       pin_rem,
  input  logic       pin_ones,
  input  logic       bit_loc,
  input  logic       bit_rem,
  input  logic       bit_ones,
  output logic       ja_in_clk,
  output logic       ja_in_pos,
  output logic       ja_in_neg,
  input  logic       ja_out_clk,
  input  logic       ja_out_pos,
  input  logic       ja_out_neg,
  output logic       line_clk,
  output logic       line_pos,
  output logic       line_neg,
  output logic       sys_clk,
  output logic       sys_pos,
  output logic       sys_neg,
  output logic [1:0] mode_state
);

  logic [NUM_CTRL-1:0] req_pin;
  logic [NUM_CTRL-1:0] req_bit;
  loop_sel_s           sel;
  loop_mode_e          mode;
  logic                ones_pos;
  logic                ones_neg;
  rail_bundle_s        tx_b, rx_b, ja_out_b, ja_in_b, line_b, sys_b;

  always_comb begin
    req_pin = '0;
    req_bit = '0;
    req_pin[CTRL_LOC]  = pin_loc;
    req_pin[CTRL_REM]  = pin_rem;
    req_pin[CTRL_ONES] = pin_ones;
    req_bit[CTRL_LOC]  = bit_loc;
    req_bit[CTRL_REM]  = bit_rem;
    req_bit[CTRL_ONES] = bit_ones;
  end

  assign tx_b     = '{clk: tx_clk, pos: tx_pos, neg: tx_neg};
  assign rx_b     = '{clk: rx_clk, pos: rx_pos, neg: rx_neg};
  assign ja_out_b = '{clk: ja_out_clk, pos: ja_out_pos, neg: ja_out_neg};

  line_loop_mode_ctl #(.N_CTRL(NUM_CTRL)) u_ctl (
    .clk     (tx_clk),
    .rst_n   (rst_n),
    .req_pin (req_pin),
    .req_bit (req_bit),
    .sel     (sel),
    .mode    (mode)
  );

  line_loop_ones_gen u_ones (
    .clk      (tx_clk),
    .rst_n    (rst_n),
    .active   (sel.ones),
    .mark_pos (ones_pos),
    .mark_neg (ones_neg)
  );

  line_loop_route u_route (
    .clk      (tx_clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .tx_b     (tx_b),
    .rx_b     (rx_b),
    .ja_out_b (ja_out_b),
    .ones_pos (ones_pos),
    .ones_neg (ones_neg),
    .ja_in_b  (ja_in_b),
    .line_b   (line_b),
    .sys_b    (sys_b)
  );

  assign ja_in_clk  = ja_in_b.clk;
  assign ja_in_pos  = ja_in_b.pos;
  assign ja_in_neg  = ja_in_b.neg;
  assign line_clk   = line_b.clk;
  assign line_pos   = line_b.pos;
  assign line_neg   = line_b.neg;
  assign sys_clk    = sys_b.clk;
  assign sys_pos    = sys_b.pos;
  assign sys_neg    = sys_b.neg;
  assign mode_state = mode;

endmodule

// File: tb/line_loop_sel_test.sv
`timescale 1ns/1ps
module line_loop_sel_test;

  logic rst_n = 1'b0;
  logic tx_clk = 1'b0;
  logic rx_clk = 1'b0;
  logic tx_pos = 1'b0, tx_neg = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic pin_loc = 1'b0, pin_rem = 1'b0, pin_ones = 1'b0;
  logic bit_loc = 1'b0, bit_rem = 1'b0, bit_ones = 1'b0;
  logic ja_in_clk, ja_in_pos, ja_in_neg;
  logic line_clk, line_pos, line_neg, sys_clk, sys_pos, sys_neg;
  logic [1:0] mode_state;

  int checks = 0;
  int errors = 0;
  bit m_loc = 0, m_rem = 0, m_ones = 0, m_phase = 0;

  always #5 tx_clk = ~tx_clk;
  always #7 rx_clk = ~rx_clk;

  line_loop_sel uut (
    .rst_n(rst_n), .tx_clk(tx_clk), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_clk(rx_clk), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .pin_loc(pin_loc), .pin_rem(pin_rem), .pin_ones(pin_ones),
    .bit_loc(bit_loc), .bit_rem(bit_rem), .bit_ones(bit_ones),
    .ja_in_clk(ja_in_clk), .ja_in_pos(ja_in_pos), .ja_in_neg(ja_in_neg),
    .ja_out_clk(ja_in_clk), .ja_out_pos(ja_in_pos), .ja_out_neg(ja_in_neg),
    .line_clk(line_clk), .line_pos(line_pos), .line_neg(line_neg),
    .sys_clk(sys_clk), .sys_pos(sys_pos), .sys_neg(sys_neg),
    .mode_state(mode_state)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_mode(bit l, bit r, bit o);
    if (r) return 2'd2;
    if (l) return 2'd1;
    if (o) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string tag_line();
    if (m_rem) return "R7";
    if (m_ones) return "R6";
    if (m_loc) return "R5";
    return "R8";
  endfunction

  task automatic check_outputs();
    logic [2:0] exp_line, exp_sys;
    if (m_rem) exp_line = {rx_clk, rx_pos, rx_neg};
    else if (m_ones) exp_line = {tx_clk, ~m_phase, m_phase};
    else exp_line = {tx_clk, tx_pos, tx_neg};
    if (m_loc && !m_rem) exp_sys = {tx_clk, tx_pos, tx_neg};
    else exp_sys = {rx_clk, rx_pos, rx_neg};
    chk("R3 mode_state", mode_state, exp_mode(m_loc, m_rem, m_ones));
    chk({tag_line(), " line_clk"}, {1'b0, line_clk}, {1'b0, exp_line[2]});
    chk({tag_line(), " line rails"}, {line_pos, line_neg}, exp_line[1:0]);
    chk((m_loc && !m_rem) ? "R4 sys" : "R8 sys",
        {sys_pos, sys_neg}, exp_sys[1:0]);
    chk("R4 sys_clk", {1'b0, sys_clk}, {1'b0, exp_sys[2]});
  endtask

  // pins: {ones,rem,loc}; bits likewise
  task automatic step(input bit [2:0] pins, input bit [2:0] bits, input bit [3:0] data);
    bit [2:0] req;
    @(negedge tx_clk);
    {pin_ones, pin_rem, pin_loc} = pins;
    {bit_ones, bit_rem, bit_loc} = bits;
    {tx_pos, tx_neg, rx_pos, rx_neg} = data;
    #1.5;
    chk("R2 before edge", mode_state, exp_mode(m_loc, m_rem, m_ones));
    @(posedge tx_clk);
    m_phase = (m_ones && !m_rem) ? ~m_phase : 1'b0;
    req = pins | bits; // R1
    {m_ones, m_rem, m_loc} = req;
    #2.5;
    check_outputs();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12.5;
    chk("R2 reset mode", mode_state, 2'd0);
    @(negedge tx_clk);
    rst_n = 1'b1;
    // R8 normal, R1 each source alone
    step(3'b000, 3'b000, 4'b1001);
    step(3'b001, 3'b000, 4'b1010);   // local by pin
    step(3'b000, 3'b001, 4'b0110);   // local by bit, R4 rx changes
    step(3'b000, 3'b001, 4'b0101);
    step(3'b010, 3'b000, 4'b0110);   // remote by pin, R7
    step(3'b000, 3'b010, 4'b1001);   // remote by bit
    // R9 entry, R6 run
    for (int i = 0; i < 6; i++) step(3'b100, 3'b000, 4'($urandom));
    step(3'b000, 3'b000, 4'b0000);
    for (int i = 0; i < 3; i++) step(3'b000, 3'b100, 4'($urandom));
    // R7 remote overrides all-ones, then R9 restart on positive
    step(3'b110, 3'b000, 4'b1010);
    step(3'b100, 3'b000, 4'b1010);
    step(3'b100, 3'b000, 4'b1010);
    // local together with all-ones: R4 and R6
    for (int i = 0; i < 4; i++) step(3'b101, 3'b000, 4'($urandom));
    step(3'b011, 3'b100, 4'b1111);
    for (int i = 0; i < 400; i++) begin
      bit [2:0] p, b;
      p = 3'($urandom);
      b = 3'($urandom);
      if ($urandom_range(0, 3) != 0) begin p[1] = 1'b0; b[1] = 1'b0; end
      if ($urandom_range(0, 2) == 0) begin p = 3'b100; b = 3'b000; end
      step(p, b, 4'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule